// File: doc/BRIEF.md
# Downstream Frame Receiver

This block sits on the memory-module side of a point-to-point serial memory channel. It takes frames sent down from the host on a set of parallel bit lanes, one lane-wide slice per beat. It collects the fixed number of beats that make up a frame and checks the frame's CRC. It then sorts the payload by a two-bit frame kind. The 72-bit tail of the payload is read as a block of write data, as two more commands, or as one more command followed by a 36-bit value for a configuration register.

Each 24-bit command names one of up to eight modules on the daisy chain. Only commands that carry this module's strapped address reach the command port. The commands are presented one per cycle in slot order. A frame that fails its CRC, or that uses the reserved kind, produces no output at all and raises a saturating error count. One lane may be marked dead. The frame is then carried on the remaining lanes at the same beat count, and only the low 10 bits of the CRC travel with it.

Top module: `sbf_rx`

## Requirements
- R1: A frame is 12 accepted beats (`sb_valid` high). A beat with `sb_first` high is always beat 0, and it abandons any partial frame. With all lanes in use, bit l of beat b is frame bit 10*(11-b)+l of a 120-bit frame F. F[119:22] is the payload P[97:0] and F[21:0] is the CRC.
- R2: The CRC runs over P serially from P[97] down to P[0], starting from all ones: fb = s[21]^P[i]; s = (s<<1) ^ (fb ? 22'h2C8E03 : 0). A frame whose received CRC differs from the computed one raises no `cmd_valid`, `wr_valid` or `cfg_valid`.
- R3: The frame kind is P[97:96] and command A is P[95:72]. The tail X is P[71:0]. Kind 00 gives command A in slot 0, plus `wr_data` = X.
- R4: Kind 01 gives three commands: A in slot 0, X[71:48] in slot 1 and X[47:24] in slot 2. X[23:0] is ignored.
- R5: Kind 10 gives A in slot 0, X[71:48] in slot 1, and `cfg_data` = X[35:0].
- R6: Kind 11 is a frame error, handled exactly like a CRC failure.
- R7: Command bits [23:21] are the module address. A command whose address differs from `local_addr` is not presented. Write data and register data are presented only when command A's address matches.
- R8: Every CRC failure or reserved-kind frame adds one to `err_cnt`, which holds at its maximum (2^ERR_W-1) and clears only on reset.
- R9: With `lane_drop_en` high, lane `lane_drop_idx` is ignored. The other lanes, taken in ascending order, form a 9-bit beat c[8:0]. Bit j of beat b is bit 9*(11-b)+j of a 108-bit frame {P, CRC[9:0]}, and only the low 10 CRC bits are compared.
- R10: For a good frame, slot 0, `wr_valid` and `cfg_valid` are high for exactly one cycle, the second cycle after the clock edge that takes beat 11. Slot 1 follows one cycle later and slot 2 one cycle after that, with `cmd_slot` giving the slot number.
- R11: After reset, all valid outputs are low and `err_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| local_addr | input | 3 | Strapped module address |
| lane_drop_en | input | 1 | One lane marked dead (degraded mode) |
| lane_drop_idx | input | 4 | Index of the dead lane |
| sb_valid | input | 1 | A beat is present on `sb_lanes` |
| sb_first | input | 1 | This beat is beat 0 of a frame |
| sb_lanes | input | 10 | One bit per lane for this beat |
| cmd_valid | output | 1 | A matching command is presented |
| cmd_slot | output | 2 | Slot the presented command came from |
| cmd_data | output | 24 | Presented command |
| wr_valid | output | 1 | Write data presented |
| wr_data | output | 72 | Write data |
| cfg_valid | output | 1 | Configuration-register data presented |
| cfg_data | output | 36 | Configuration-register data |
| err_cnt | output | ERR_W | Saturating count of rejected frames |

## Verification
A beat counter that drifts shows up two cycles after the next frame's last beat: the payload comes out rotated, the CRC no longer matches, and the error count rises where a command was due. A wrong slot queue shows up within three cycles of a good frame, as commands out of order, a missing slot or a foreign address on the command port. In degraded mode, a compaction that uses the wrong lane turns every frame into an error. A mask set to the wrong CRC width lets a frame with a damaged upper CRC through in full mode.

// File: rtl/sbf_pkg.sv
// Package: field widths, frame kinds and CRC constants shared by the
// downstream frame receiver. Assumes a 98-bit payload and a 22-bit CRC.
package sbf_pkg;
    localparam int PAY_W   = 98;
    localparam int CRC_W   = 22;
    localparam int CMD_W   = 24;
    localparam int ADDR_W  = 3;
    localparam int EXT_W   = 72;
    localparam int CFG_W   = 36;
    localparam int KIND_W  = 2;
    localparam int NSLOT   = 3;
    localparam int SLOT_W  = $clog2(NSLOT);
    localparam logic [CRC_W-1:0] CRC_POLY = 22'h2C8E03;
    localparam logic [CRC_W-1:0] CRC_INIT = '1;

    typedef enum logic [KIND_W-1:0] {
        KIND_CMD_WR  = 2'b00,
        KIND_CMD3    = 2'b01,
        KIND_CMD_CFG = 2'b10,
        KIND_RSVD    = 2'b11
    } frame_kind_e;
endpackage

// File: rtl/sbf_crc.sv
// Module: combinational CRC over the whole payload, MSB first, seeded with
// all ones. Assumes the payload is stable in the cycle it is evaluated.
module sbf_crc
    import sbf_pkg::*;
(
    input  logic [PAY_W-1:0] payload,
    output logic [CRC_W-1:0] crc
);
    // Serial LFSR unrolled over every payload bit.
    always_comb begin
        logic [CRC_W-1:0] s;
        logic             fb;
        s = CRC_INIT;
        for (int i = PAY_W - 1; i >= 0; i--) begin
            fb = s[CRC_W-1] ^ payload[i];
            s  = {s[CRC_W-2:0], 1'b0};
            if (fb) s = s ^ CRC_POLY;
        end
        crc = s;
    end
endmodule

// File: rtl/sbf_gather.sv
// Module: collects lane beats into a frame shift register. It counts the
// beats, restarts on a first-beat flag, and squeezes out a dead lane.
// Assumes the drop controls are static while frames arrive.
module sbf_gather #(
    parameter int LANES = 10,
    parameter int BEATS = 12,
    localparam int FRAME_W = LANES * BEATS,
    localparam int BEAT_W  = $clog2(BEATS),
    localparam int IDX_W   = $clog2(LANES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_first,
    input  logic [LANES-1:0]   in_lanes,
    input  logic               drop_en,
    input  logic [IDX_W-1:0]   drop_idx,
    output logic [FRAME_W-1:0] frame,
    output logic               frame_vld
);
    logic [LANES-2:0]   comp;
    logic [BEAT_W-1:0]  beat_q;
    logic [BEAT_W-1:0]  idx;
    logic [FRAME_W-1:0] sr_q;

    // Compact the live lanes: those above the dead one move down by one.
    for (genvar l = 0; l < LANES - 1; l++) begin : g_comp
        assign comp[l] = (drop_idx > IDX_W'(l)) ? in_lanes[l] : in_lanes[l+1];
    end

    // Position of the current beat within its frame.
    assign idx = in_first ? '0 : beat_q;

    // Shift beats in, count them, and flag a complete frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q    <= '0;
            sr_q      <= '0;
            frame_vld <= 1'b0;
        end else begin
            frame_vld <= 1'b0;
            if (in_valid) begin
                if (drop_en) sr_q <= {sr_q[FRAME_W-LANES:0], comp};
                else         sr_q <= {sr_q[FRAME_W-LANES-1:0], in_lanes};
                if (idx == BEAT_W'(BEATS - 1)) begin
                    beat_q    <= '0;
                    frame_vld <= 1'b1;
                end else begin
                    beat_q <= idx + 1'b1;
                end
            end
        end
    end

    assign frame = sr_q;
endmodule

// File: rtl/sbf_decode.sv
// Module: checks the CRC, decodes the frame kind, filters commands by
// module address, queues them in slot order and counts rejected frames.
// Assumes frames arrive at least NSLOT cycles apart.
module sbf_decode
    import sbf_pkg::*;
#(
    parameter int ERR_W     = 8,
    parameter int CRC_DEG_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_vld,
    input  logic [PAY_W-1:0]  payload,
    input  logic [CRC_W-1:0]  rx_crc,
    input  logic [CRC_W-1:0]  calc_crc,
    input  logic              drop_en,
    input  logic [ADDR_W-1:0] local_addr,
    output logic              cmd_valid,
    output logic [SLOT_W-1:0] cmd_slot,
    output logic [CMD_W-1:0]  cmd_data,
    output logic              wr_valid,
    output logic [EXT_W-1:0]  wr_data,
    output logic              cfg_valid,
    output logic [CFG_W-1:0]  cfg_data,
    output logic [ERR_W-1:0]  err_cnt
);
    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    frame_kind_e       kind;
    logic [CMD_W-1:0]  slot_cmd [NSLOT];
    logic [NSLOT-1:0]  slot_use;
    logic [NSLOT-1:0]  slot_hit;
    logic [EXT_W-1:0]  ext;
    logic              crc_ok;
    logic              good;
    logic              bad;
    logic [CMD_W-1:0]  q_cmd  [NSLOT];
    logic [SLOT_W-1:0] q_slot [NSLOT];
    logic [NSLOT-1:0]  q_vld;

    assign kind        = frame_kind_e'(payload[PAY_W-1 -: KIND_W]);
    assign ext         = payload[EXT_W-1:0];
    assign slot_cmd[0] = payload[PAY_W-KIND_W-1 -: CMD_W];

    // The tail commands are packed from the top of the 72-bit tail.
    for (genvar k = 1; k < NSLOT; k++) begin : g_slot
        assign slot_cmd[k] = ext[EXT_W-1-(k-1)*CMD_W -: CMD_W];
    end

    // Address filter, one comparator per slot.
    for (genvar k = 0; k < NSLOT; k++) begin : g_hit
        assign slot_hit[k] = (slot_cmd[k][CMD_W-1 -: ADDR_W] == local_addr);
    end

    // Which slots the frame kind fills.
    always_comb begin
        slot_use = '0;
        unique case (kind)
            KIND_CMD_WR:  slot_use = 3'b001;
            KIND_CMD3:    slot_use = 3'b111;
            KIND_CMD_CFG: slot_use = 3'b011;
            KIND_RSVD:    slot_use = 3'b000;
        endcase
    end

    // CRC compare, narrowed to the low bits in degraded mode.
    always_comb begin
        if (drop_en) crc_ok = (calc_crc[CRC_DEG_W-1:0] == rx_crc[CRC_DEG_W-1:0]);
        else         crc_ok = (calc_crc == rx_crc);
    end

    assign good = frame_vld && crc_ok && (kind != KIND_RSVD);
    assign bad  = frame_vld && !good;

    // Slot queue: load on a good frame, otherwise advance one slot per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_vld <= '0;
            for (int i = 0; i < NSLOT; i++) begin
                q_cmd[i]  <= '0;
                q_slot[i] <= '0;
            end
        end else if (good) begin
            for (int i = 0; i < NSLOT; i++) begin
                q_cmd[i]  <= slot_cmd[i];
                q_slot[i] <= SLOT_W'(i);
                q_vld[i]  <= slot_use[i] && slot_hit[i];
            end
        end else begin
            for (int i = 0; i < NSLOT - 1; i++) begin
                q_cmd[i]  <= q_cmd[i+1];
                q_slot[i] <= q_slot[i+1];
                q_vld[i]  <= q_vld[i+1];
            end
            q_vld[NSLOT-1] <= 1'b0;
        end
    end

    // Data outputs, gated by command A's address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid  <= 1'b0;
            cfg_valid <= 1'b0;
            wr_data   <= '0;
            cfg_data  <= '0;
        end else begin
            wr_valid  <= good && (kind == KIND_CMD_WR) && slot_hit[0];
            cfg_valid <= good && (kind == KIND_CMD_CFG) && slot_hit[0];
            if (good && kind == KIND_CMD_WR)  wr_data  <= ext;
            if (good && kind == KIND_CMD_CFG) cfg_data <= ext[CFG_W-1:0];
        end
    end

    // Saturating count of rejected frames.
    always_ff @(posedge clk) begin
        if (!rst_n)                        err_cnt <= '0;
        else if (bad && err_cnt != ERR_MAX) err_cnt <= err_cnt + 1'b1;
    end

    assign cmd_valid = q_vld[0];
    assign cmd_data  = q_cmd[0];
    assign cmd_slot  = q_slot[0];
endmodule

// File: rtl/sbf_rx.sv
// Module: top of the downstream frame receiver. It gathers beats, takes the
// payload and CRC fields for the lane mode in use, and decodes the frame.
// Assumes the drop controls and local_addr are straps.
module sbf_rx
    import sbf_pkg::*;
#(
    parameter int LANES = 10,
    parameter int BEATS = 12,
    parameter int ERR_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        local_addr,
    input  logic                     lane_drop_en,
    input  logic [$clog2(LANES)-1:0] lane_drop_idx,
    input  logic                     sb_valid,
    input  logic                     sb_first,
    input  logic [LANES-1:0]         sb_lanes,
    output logic                     cmd_valid,
    output logic [SLOT_W-1:0]        cmd_slot,
    output logic [CMD_W-1:0]         cmd_data,
    output logic                     wr_valid,
    output logic [EXT_W-1:0]         wr_data,
    output logic                     cfg_valid,
    output logic [CFG_W-1:0]         cfg_data,
    output logic [ERR_W-1:0]         err_cnt
);
    localparam int FRAME_W     = LANES * BEATS;
    localparam int FRAME_DEG_W = (LANES - 1) * BEATS;
    localparam int CRC_DEG_W   = FRAME_DEG_W - PAY_W;

    logic [FRAME_W-1:0] frame;
    logic               frame_vld;
    logic [PAY_W-1:0]   payload;
    logic [CRC_W-1:0]   rx_crc;
    logic [CRC_W-1:0]   calc_crc;

    sbf_gather #(.LANES(LANES), .BEATS(BEATS)) u_gather (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (sb_valid),
        .in_first  (sb_first),
        .in_lanes  (sb_lanes),
        .drop_en   (lane_drop_en),
        .drop_idx  (lane_drop_idx),
        .frame     (frame),
        .frame_vld (frame_vld)
    );

    // Field split for full or degraded lane mode.
    always_comb begin
        if (lane_drop_en) begin
            payload = frame[FRAME_DEG_W-1 -: PAY_W];
            rx_crc  = {{(CRC_W-CRC_DEG_W){1'b0}}, frame[CRC_DEG_W-1:0]};
        end else begin
            payload = frame[FRAME_W-1 -: PAY_W];
            rx_crc  = frame[CRC_W-1:0];
        end
    end

    sbf_crc u_crc (
        .payload (payload),
        .crc     (calc_crc)
    );

    sbf_decode #(.ERR_W(ERR_W), .CRC_DEG_W(CRC_DEG_W)) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_vld  (frame_vld),
        .payload    (payload),
        .rx_crc     (rx_crc),
        .calc_crc   (calc_crc),
        .drop_en    (lane_drop_en),
        .local_addr (local_addr),
        .cmd_valid  (cmd_valid),
        .cmd_slot   (cmd_slot),
        .cmd_data   (cmd_data),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .cfg_valid  (cfg_valid),
        .cfg_data   (cfg_data),
        .err_cnt    (err_cnt)
    );
endmodule

// File: rtl/sbf_rx_chk.sv
// Module: port-level properties of the downstream frame receiver, bound
// to every instance of the top.
module sbf_rx_chk
    import sbf_pkg::*;
#(
    parameter int ERR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] local_addr,
    input logic              cmd_valid,
    input logic [SLOT_W-1:0] cmd_slot,
    input logic [CMD_W-1:0]  cmd_data,
    input logic              wr_valid,
    input logic              cfg_valid,
    input logic [ERR_W-1:0]  err_cnt
);
    // R7
    cmd_addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_data[CMD_W-1 -: ADDR_W] == local_addr));

    // R3
    wr_with_slot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (cmd_valid && cmd_slot == '0));

    // R5
    cfg_with_slot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (cmd_valid && cmd_slot == '0 && !wr_valid));

    // R8
    err_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt >= $past(err_cnt));

    // R2
    err_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt != $past(err_cnt)) |-> (!cmd_valid && !wr_valid && !cfg_valid));

    // R10
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);
endmodule

bind sbf_rx sbf_rx_chk #(.ERR_W(ERR_W)) u_sbf_rx_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .local_addr (local_addr),
    .cmd_valid  (cmd_valid),
    .cmd_slot   (cmd_slot),
    .cmd_data   (cmd_data),
    .wr_valid   (wr_valid),
    .cfg_valid  (cfg_valid),
    .err_cnt    (err_cnt)
);

// File: tb/test_sbf_rx.sv
`timescale 1ns/1ps
// Directed bench for the downstream frame receiver.
module test_sbf_rx;
    localparam int ERR_W = 4;
    localparam logic [21:0] POLY = 22'h2C8E03;
    localparam logic [2:0]  MY_ADDR = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  local_addr = MY_ADDR;
    logic        lane_drop_en = 1'b0;
    logic [3:0]  lane_drop_idx = 4'd0;
    logic        sb_valid = 1'b0;
    logic        sb_first = 1'b0;
    logic [9:0]  sb_lanes = '0;
    logic        cmd_valid;
    logic [1:0]  cmd_slot;
    logic [23:0] cmd_data;
    logic        wr_valid;
    logic [71:0] wr_data;
    logic        cfg_valid;
    logic [35:0] cfg_data;
    logic [ERR_W-1:0] err_cnt;

    int n_chk = 0;
    int n_fail = 0;
    int exp_err = 0;
    bit done = 1'b0;

    logic [9:0]  beat_tab [12];
    logic        ov [3];
    logic [1:0]  os [3];
    logic [23:0] od [3];
    logic        o_wv, o_fv, o_quiet;
    logic [71:0] o_wd;
    logic [35:0] o_fd;

    always #2.5 clk = ~clk;

    sbf_rx #(.ERR_W(ERR_W)) i_sbf_rx (
        .clk(clk), .rst_n(rst_n), .local_addr(local_addr),
        .lane_drop_en(lane_drop_en), .lane_drop_idx(lane_drop_idx),
        .sb_valid(sb_valid), .sb_first(sb_first), .sb_lanes(sb_lanes),
        .cmd_valid(cmd_valid), .cmd_slot(cmd_slot), .cmd_data(cmd_data),
        .wr_valid(wr_valid), .wr_data(wr_data),
        .cfg_valid(cfg_valid), .cfg_data(cfg_data), .err_cnt(err_cnt)
    );

    task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [21:0] crc22(input logic [97:0] p);
        logic [21:0] s = '1;
        for (int i = 97; i >= 0; i--) begin
            logic fb = s[21] ^ p[i];
            s = {s[20:0], 1'b0};
            if (fb) s = s ^ POLY;
        end
        return s;
    endfunction

    function automatic logic [23:0] mkcmd(input logic [2:0] a, input logic [20:0] body);
        return {a, body};
    endfunction

    // Lay a payload out over 12 beats per R1 / R9.
    task automatic build(input logic [97:0] pay, input bit deg, input int drop);
        logic [21:0]  c = crc22(pay);
        logic [119:0] f = {pay, c};
        logic [107:0] f9 = {pay, c[9:0]};
        for (int b = 0; b < 12; b++)
            for (int l = 0; l < 10; l++) begin
                if (!deg)           beat_tab[b][l] = f[10*(11-b)+l];
                else if (l == drop) beat_tab[b][l] = b[0];
                else                beat_tab[b][l] = f9[9*(11-b)+((l < drop) ? l : l-1)];
            end
    endtask

    task automatic send(input int nb);
        for (int b = 0; b < nb; b++) begin
            @(negedge clk);
            sb_valid = 1'b1;
            sb_first = (b == 0);
            sb_lanes = beat_tab[b];
        end
        @(negedge clk);
        sb_valid = 1'b0;
        sb_first = 1'b0;
    endtask

    // Capture the three emission cycles and the one after (R10).
    task automatic observe();
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            ov[k] = cmd_valid; os[k] = cmd_slot; od[k] = cmd_data;
            if (k == 0) begin
                o_wv = wr_valid; o_wd = wr_data; o_fv = cfg_valid; o_fd = cfg_data;
            end
        end
        @(negedge clk);
        o_quiet = !cmd_valid && !wr_valid && !cfg_valid;
    endtask

    task automatic exp_slot(input string tag, input int k, input bit v, input logic [23:0] d);
        chk({tag, " valid"}, 72'(ov[k]), 72'(v));
        if (v) begin
            chk({tag, " slot"}, 72'(os[k]), 72'(k));
            chk({tag, " data"}, 72'(od[k]), 72'(d));
        end
    endtask

    task automatic bump_err();
        if (exp_err < (1 << ERR_W) - 1) exp_err++;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R11 cmd_valid", 72'(cmd_valid), 72'(0));
        chk("R11 wr_valid", 72'(wr_valid), 72'(0));
        chk("R11 cfg_valid", 72'(cfg_valid), 72'(0));
        chk("R11 err_cnt", 72'(err_cnt), 72'(0));
    endtask

    task automatic t_cmd_wr();
        logic [23:0] a = mkcmd(MY_ADDR, 21'h0ABCDE);
        logic [71:0] x = 72'hA5_1234_5678_9ABC_DEF0;
        build({2'b00, a, x}, 0, 0); send(12); observe();
        exp_slot("R3 slot0", 0, 1, a);
        chk("R10 wr_valid timing", 72'(o_wv), 72'(1));
        chk("R3 wr_data", o_wd, x);
        chk("R1 frame bit order via wr_data", o_wd[7:0], 72'hF0);
        exp_slot("R10 no slot1", 1, 0, '0);
        chk("R10 quiet after", 72'(o_quiet), 72'(1));
    endtask

    task automatic t_cmd3();
        logic [23:0] a = mkcmd(MY_ADDR, 21'h111111);
        logic [23:0] b = mkcmd(3'd2,    21'h022222);
        logic [23:0] c = mkcmd(MY_ADDR, 21'h133333);
        build({2'b01, a, b, c, 24'hFFFFFF}, 0, 0); send(12); observe();
        exp_slot("R4 slot0", 0, 1, a);
        exp_slot("R7 slot1 foreign address", 1, 0, b);
        exp_slot("R4 slot2", 2, 1, c);
        chk("R4 no write data", 72'(o_wv), 72'(0));
        b = mkcmd(MY_ADDR, 21'h044444);
        build({2'b01, a, b, c, 24'h0}, 0, 0); send(12); observe();
        exp_slot("R4 order slot0", 0, 1, a);
        exp_slot("R4 order slot1", 1, 1, b);
        exp_slot("R4 order slot2", 2, 1, c);
    endtask

    task automatic t_cmd_cfg();
        logic [23:0] a = mkcmd(MY_ADDR, 21'h155555);
        logic [23:0] b = mkcmd(MY_ADDR, 21'h066666);
        logic [35:0] r = 36'h9_8765_4321;
        build({2'b10, a, b, 12'hFFF, r}, 0, 0); send(12); observe();
        exp_slot("R5 slot0", 0, 1, a);
        exp_slot("R5 slot1", 1, 1, b);
        exp_slot("R5 no slot2", 2, 0, '0);
        chk("R5 cfg_valid", 72'(o_fv), 72'(1));
        chk("R5 cfg_data", 72'(o_fd), 72'(r));
        chk("R5 no wr_valid", 72'(o_wv), 72'(0));
    endtask

    task automatic t_addr_miss();
        build({2'b00, mkcmd(3'd4, 21'h0), 72'h1}, 0, 0); send(12); observe();
        chk("R7 foreign cmd hidden", 72'(ov[0]), 72'(0));
        chk("R7 foreign wr hidden", 72'(o_wv), 72'(0));
        chk("R7 err unchanged", 72'(err_cnt), 72'(exp_err));
    endtask

    task automatic t_crc_bad();
        build({2'b00, mkcmd(MY_ADDR, 21'h1), 72'h2}, 0, 0);
        beat_tab[4][2] = ~beat_tab[4][2];
        send(12); observe(); bump_err();
        chk("R2 bad payload no cmd", 72'(ov[0]), 72'(0));
        chk("R2 bad payload no wr", 72'(o_wv), 72'(0));
        chk("R8 err count", 72'(err_cnt), 72'(exp_err));
        build({2'b00, mkcmd(MY_ADDR, 21'h1), 72'h2}, 0, 0);
        beat_tab[10][5] = ~beat_tab[10][5];
        send(12); observe(); bump_err();
        chk("R2 upper CRC bit checked in full mode", 72'(ov[0]), 72'(0));
        chk("R8 err count 2", 72'(err_cnt), 72'(exp_err));
    endtask

    task automatic t_rsvd();
        build({2'b11, mkcmd(MY_ADDR, 21'h7), 72'h3}, 0, 0); send(12); observe();
        bump_err();
        chk("R6 reserved no cmd", 72'(ov[0]), 72'(0));
        chk("R6 reserved no data", 72'(o_wv | o_fv), 72'(0));
        chk("R6 err count", 72'(err_cnt), 72'(exp_err));
    endtask

    task automatic t_degraded();
        logic [23:0] a = mkcmd(MY_ADDR, 21'h0F0F0F);
        logic [71:0] x = 72'h3C_0102_0304_0506_0708;
        lane_drop_en = 1'b1; lane_drop_idx = 4'd3;
        build({2'b00, a, x}, 1, 3); send(12); observe();
        exp_slot("R9 degraded slot0", 0, 1, a);
        chk("R9 degraded wr_data", o_wd, x);
        chk("R9 dead lane ignored, err", 72'(err_cnt), 72'(exp_err));
        build({2'b00, a, x}, 1, 3);
        beat_tab[11][0] = ~beat_tab[11][0];
        send(12); observe(); bump_err();
        chk("R9 short CRC still checked", 72'(ov[0]), 72'(0));
        chk("R9 err count", 72'(err_cnt), 72'(exp_err));
        lane_drop_en = 1'b0; lane_drop_idx = 4'd0;
    endtask

    task automatic t_resync();
        logic [23:0] a = mkcmd(MY_ADDR, 21'h1ABABA);
        build({2'b00, mkcmd(MY_ADDR, 21'h0), 72'h0}, 0, 0); send(5);
        repeat (3) @(negedge clk);
        build({2'b00, a, 72'h77}, 0, 0); send(12); observe();
        exp_slot("R1 restart on first beat", 0, 1, a);
        chk("R1 restart wr_data", o_wd, 72'h77);
        chk("R1 restart err", 72'(err_cnt), 72'(exp_err));
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 14; i++) begin
            build({2'b11, 24'h0, 72'h0}, 0, 0); send(12); observe(); bump_err();
        end
        chk("R8 err saturates", 72'(err_cnt), 72'((1 << ERR_W) - 1));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cmd_wr();
        t_cmd3();
        t_cmd_cfg();
        t_addr_miss();
        t_crc_bad();
        t_rsvd();
        t_degraded();
        t_resync();
        t_saturate();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule